// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read/write cache built from a direct-mapped line array and a small fully associative victim buffer. The victim buffer sits on the array's refill path and is loaded only with lines that the array pushes out. A processor-side request is looked up in the array first. On an array miss, the buffer is searched. A buffer hit swaps the wanted line and the displaced array line in one step, at a cost of one extra cycle. When both structures miss, the line is fetched from memory and the displaced array line drops into the buffer.

The processor issues word requests on a valid-only port while `stall` is low, and gets one `rsp_valid` pulse per request. The memory side moves whole lines. A refill read is held until `mem_rd_valid`. A writeback is held until `mem_wr_ack`. Writebacks happen only when a dirty line leaves the victim buffer.

The controller has four states. `ST_IDLE` accepts requests and finishes array hits. It moves to `ST_SWAP` on a buffer hit. On a full miss it moves to `ST_WRBACK` if the buffer slot to be reused holds a dirty line that must leave, and to `ST_FETCH` otherwise. `ST_SWAP` always returns to `ST_IDLE`. `ST_WRBACK` goes to `ST_FETCH` when `mem_wr_ack` arrives. `ST_FETCH` goes back to `ST_IDLE` when `mem_rd_valid` arrives.

Top module: `vc_cache`

## Requirements
- R1: An access that hits the direct-mapped array is answered with `rsp_valid` on the cycle after it is accepted, and `stall` stays low throughout. A read returns the current word. A write stores `req_wdata` into the word selected by address bits [3:2].
- R2: On an array miss, the victim buffer is searched before any memory request is made. A buffer hit is answered exactly two cycles after acceptance, with no memory traffic.
- R3: A buffer hit moves the requested line into the array. The line it displaces moves into the same buffer entry, so that both lines can be reached afterwards without memory traffic.
- R4: When both structures miss, the line at address bits [11:4] is read from memory and placed in the array. The displaced array line, if valid, goes to the buffer. A fetched line is never written into the buffer.
- R5: A written line keeps its data and its dirty state through every swap and through every move between the array and the buffer.
- R6: When the buffer needs a slot, an invalid entry is used before any valid entry. If every entry is valid, the least recently filled entry is replaced.
- R7: A dirty line leaving the buffer is written back to memory at its own line address before the refill read for the new line begins. Clean lines are dropped without a write.
- R8: `stall` is high from the cycle after a missed access is accepted until the cycle its response appears. `rsp_valid` is never high together with `stall`.
- R9: At most one memory request is active at a time. A refill request holds its address until `mem_rd_valid`.
- R10: After reset, no line is valid, `stall` and `rsp_valid` are low, and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present (taken when `stall` is low) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write data |
| stall | output | 1 | Busy with a miss; no request accepted |
| rsp_valid | output | 1 | Response for the accepted request |
| rsp_rdata | output | WORD_W | Read data (word before any write) |
| mem_rd_req | output | 1 | Line refill request |
| mem_rd_addr | output | ADDR_W-4 | Line address to fetch |
| mem_rd_valid | input | 1 | Refill data present |
| mem_rd_data | input | LINE_W | Refill line |
| mem_wr_req | output | 1 | Line writeback request |
| mem_wr_addr | output | ADDR_W-4 | Line address written back |
| mem_wr_data | output | LINE_W | Writeback line |
| mem_wr_ack | input | 1 | Writeback accepted |

## Verification
The checker watches the port protocol on every cycle. It confirms that a response never appears together with `stall`, that only one memory request is active at a time, and that a refill address stays stable until its data arrives. It also confirms that a swap finishes in the very next cycle and that a writeback handshake always leads straight into a refill. Only the bench's scenarios can show the content-level behaviour: data compared against a reference memory, alternating conflicting lines that land in the buffer, the dirty bit surviving several swaps, and the choice of which buffer entry is replaced. The bench observes these through access latency and through the count and address of writebacks.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWAP,
        ST_WRBACK,
        ST_FETCH
    } vc_state_e;
endpackage

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid_vec,
    input  logic                 touch,
    input  logic [$clog2(N)-1:0] touch_idx,
    output logic [$clog2(N)-1:0] sel_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] age [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)          age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid_vec[i] && !found) begin
                sel_idx = IW'(i);
                found   = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age[i] == IW'(N-1)) sel_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vc_vbuf.sv
module vc_vbuf #(
    parameter int N      = 4,
    parameter int LA_W   = 8,
    parameter int LINE_W = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LA_W-1:0]      look_la,
    output logic                 hit,
    output logic [$clog2(N)-1:0] hit_idx,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [LA_W-1:0]      rd_la,
    output logic [LINE_W-1:0]    rd_data,
    output logic                 rd_dirty,
    output logic [N-1:0]         valid_vec,
    output logic [N-1:0]         dirty_vec,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [LA_W-1:0]      wr_la,
    input  logic [LINE_W-1:0]    wr_data,
    input  logic                 wr_valid,
    input  logic                 wr_dirty
);
    localparam int IW = $clog2(N);

    logic [LA_W-1:0]   la_q   [N];
    logic [LINE_W-1:0] data_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            dirty_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_idx] <= wr_valid;
            dirty_vec[wr_idx] <= wr_dirty && wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            la_q[wr_idx]   <= wr_la;
            data_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_vec[i] && la_q[i] == look_la) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign rd_la    = la_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
endmodule

// File: rtl/vc_cache.sv
module vc_cache
    import vc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 64,
    parameter int VICT_N     = 4,
    parameter int LINE_W     = WORD_W * LINE_WORDS,
    parameter int LA_W       = ADDR_W - $clog2(LINE_WORDS * WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              stall,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_rd_req,
    output logic [LA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [LA_W-1:0]   mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int VI_W   = $clog2(VICT_N);

    function automatic logic [LINE_W-1:0] put_word(
        input logic [LINE_W-1:0] line, input logic [WSEL_W-1:0] ws,
        input logic wr, input logic [WORD_W-1:0] wd);
        put_word = line;
        if (wr) put_word[ws*WORD_W +: WORD_W] = wd;
    endfunction

    vc_state_e state, state_nx;

    logic [SETS-1:0]   m_valid, m_dirty;
    logic [TAG_W-1:0]  m_tag  [SETS];
    logic [LINE_W-1:0] m_data [SETS];

    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic [WORD_W-1:0] q_wdata;
    logic [VI_W-1:0]   vidx_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic [WORD_W-1:0] cur_wdata;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [WSEL_W-1:0] cur_ws;
    logic              accept, m_hit;

    logic              vb_hit;
    logic [VI_W-1:0]   vb_hit_idx, lru_sel;
    logic [LA_W-1:0]   vb_rd_la;
    logic [LINE_W-1:0] vb_rd_data;
    logic              vb_rd_dirty;
    logic [VICT_N-1:0] vb_valid, vb_dirty;
    logic              vb_wr_en;

    logic              mw_en, mw_dirty, done;
    logic [LINE_W-1:0] base_line;

    assign cur_addr  = (state == ST_IDLE) ? req_addr  : q_addr;
    assign cur_write = (state == ST_IDLE) ? req_write : q_write;
    assign cur_wdata = (state == ST_IDLE) ? req_wdata : q_wdata;
    assign cur_idx   = cur_addr[OFF_W +: IDX_W];
    assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_ws    = cur_addr[BYTE_W +: WSEL_W];
    assign accept    = (state == ST_IDLE) && req_valid;
    assign m_hit     = m_valid[cur_idx] && (m_tag[cur_idx] == cur_tag);

    vc_vbuf #(.N(VICT_N), .LA_W(LA_W), .LINE_W(LINE_W)) u_vbuf (
        .clk(clk), .rst_n(rst_n),
        .look_la(cur_addr[ADDR_W-1:OFF_W]),
        .hit(vb_hit), .hit_idx(vb_hit_idx),
        .rd_idx(vidx_q), .rd_la(vb_rd_la), .rd_data(vb_rd_data),
        .rd_dirty(vb_rd_dirty), .valid_vec(vb_valid), .dirty_vec(vb_dirty),
        .wr_en(vb_wr_en), .wr_idx(vidx_q),
        .wr_la({m_tag[cur_idx], cur_idx}), .wr_data(m_data[cur_idx]),
        .wr_valid(m_valid[cur_idx]), .wr_dirty(m_dirty[cur_idx])
    );

    vc_lru #(.N(VICT_N)) u_lru (
        .clk(clk), .rst_n(rst_n), .valid_vec(vb_valid),
        .touch(vb_wr_en), .touch_idx(vidx_q), .sel_idx(lru_sel)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && !m_hit) begin
                if (vb_hit)
                    state_nx = ST_SWAP;
                else if (m_valid[cur_idx] && vb_valid[lru_sel] && vb_dirty[lru_sel])
                    state_nx = ST_WRBACK;
                else
                    state_nx = ST_FETCH;
            end
            ST_SWAP:   state_nx = ST_IDLE;
            ST_WRBACK: if (mem_wr_ack)   state_nx = ST_FETCH;
            ST_FETCH:  if (mem_rd_valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        stall      = (state != ST_IDLE);
        mem_rd_req = (state == ST_FETCH);
        mem_wr_req = (state == ST_WRBACK);
        mw_en      = 1'b0;
        mw_dirty   = 1'b0;
        vb_wr_en   = 1'b0;
        base_line  = m_data[cur_idx];
        unique case (state)
            ST_IDLE: begin
                mw_en    = accept && m_hit;
                mw_dirty = m_dirty[cur_idx] || cur_write;
            end
            ST_SWAP: begin
                mw_en     = 1'b1;
                base_line = vb_rd_data;
                mw_dirty  = vb_rd_dirty || cur_write;
                vb_wr_en  = 1'b1;
            end
            ST_WRBACK: ;
            ST_FETCH: begin
                mw_en     = mem_rd_valid;
                base_line = mem_rd_data;
                mw_dirty  = cur_write;
                vb_wr_en  = mem_rd_valid && m_valid[cur_idx];
            end
            default: ;
        endcase
        done = mw_en;
    end

    assign mem_rd_addr = q_addr[ADDR_W-1:OFF_W];
    assign mem_wr_addr = vb_rd_la;
    assign mem_wr_data = vb_rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid   <= '0;
            m_dirty   <= '0;
            rsp_valid <= 1'b0;
            vidx_q    <= '0;
        end else begin
            rsp_valid <= done;
            if (mw_en) begin
                m_valid[cur_idx] <= 1'b1;
                m_dirty[cur_idx] <= mw_dirty;
            end
            if (accept) vidx_q <= vb_hit ? vb_hit_idx : lru_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            q_wdata <= req_wdata;
        end
        if (mw_en) begin
            m_tag[cur_idx]  <= cur_tag;
            m_data[cur_idx] <= put_word(base_line, cur_ws, cur_write, cur_wdata);
        end
        if (done) rsp_rdata <= base_line[cur_ws*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk
    import vc_pkg::*;
#(
    parameter int LA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input vc_state_e       state,
    input logic            stall,
    input logic            rsp_valid,
    input logic            mem_rd_req,
    input logic [LA_W-1:0] mem_rd_addr,
    input logic            mem_rd_valid,
    input logic            mem_wr_req,
    input logic            mem_wr_ack
);
    // R8
    rsp_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !stall);
    // R8
    mem_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> stall);
    // R9
    single_mem_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
    // R9
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R2
    swap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |=> (rsp_valid && !stall && !mem_rd_req));
    // R7
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack) |=> mem_rd_req);
endmodule

bind vc_cache vc_cache_chk #(.LA_W(LA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .stall(stall),
    .rsp_valid(rsp_valid), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack)
);

// File: tb/vc_cache_test.sv
`timescale 1ns/1ps
module vc_cache_test;
    localparam int AW = 12, WW = 32, LW = 128, LAW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_wdata = '0;
    logic stall, rsp_valid, mem_rd_req, mem_wr_req;
    logic [WW-1:0] rsp_rdata;
    logic [LAW-1:0] mem_rd_addr, mem_wr_addr;
    logic mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
    logic [LW-1:0] mem_rd_data = '0;
    logic [LW-1:0] mem_wr_data;

    vc_cache uut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    logic [WW-1:0] backing [1024];
    logic [WW-1:0] model [1024];
    int wb_count = 0, ev = 0, last_wr_ev = 0, last_rd_ev = 0;
    logic [LAW-1:0] last_wb_addr = '0, last_rd_addr = '0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                ev++; last_rd_ev = ev; last_rd_addr = mem_rd_addr;
                repeat (5) @(negedge clk);
                for (int w = 0; w < 4; w++)
                    mem_rd_data[w*32 +: 32] = backing[{mem_rd_addr, w[1:0]}];
                mem_rd_valid = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end else if (mem_wr_req) begin
                ev++; last_wr_ev = ev; last_wb_addr = mem_wr_addr; wb_count++;
                for (int w = 0; w < 4; w++)
                    backing[{mem_wr_addr, w[1:0]}] = mem_wr_data[w*32 +: 32];
                repeat (2) @(negedge clk);
                mem_wr_ack = 1'b1;
                @(negedge clk);
                mem_wr_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                          output logic [WW-1:0] rd, output int lat, output int stalls);
        @(negedge clk);
        while (stall) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; stalls = 0;
        while (!rsp_valid && lat < 200) begin
            if (stall) stalls++;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        if (wr) model[a[11:2]] = wd;
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [1:0]  cls;   // 0 array hit, 1 buffer hit, 2 full miss
    } vec_t;

    localparam logic [31:0] WV = 32'hDEADBEEF;
    localparam vec_t VEC [8] = '{
        '{1'b0, 12'h010, 32'h0, 2'd2},
        '{1'b0, 12'h010, 32'h0, 2'd0},
        '{1'b1, 12'h014, WV,    2'd0},
        '{1'b0, 12'h410, 32'h0, 2'd2},
        '{1'b0, 12'h010, 32'h0, 2'd1},
        '{1'b0, 12'h014, 32'h0, 2'd0},
        '{1'b0, 12'h410, 32'h0, 2'd1},
        '{1'b0, 12'h014, 32'h0, 2'd1}
    };

    task automatic miss_read(input logic [AW-1:0] a, input string req);
        logic [WW-1:0] rd; int lat, st;
        access(1'b0, a, '0, rd, lat, st);
        check(lat > 2, req, lat, 3);
        check(rd == model[a[11:2]], req, rd, model[a[11:2]]);
        check(last_rd_addr == a[11:4], req, last_rd_addr, a[11:4]);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            backing[i] = 32'hA5000000 ^ (i * 32'h00010001);
            model[i]   = backing[i];
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!stall && !rsp_valid && !mem_rd_req && !mem_wr_req, "R10",
              {stall, rsp_valid, mem_rd_req, mem_wr_req}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < 8; k++) begin
            logic [WW-1:0] rd; int lat, st, exp_lat;
            access(VEC[k].wr, VEC[k].addr, VEC[k].wd, rd, lat, st);
            if (VEC[k].cls == 2'd0) begin
                check(lat == 1 && st == 0, "R1 array hit", lat, 1);
            end else if (VEC[k].cls == 2'd1) begin
                check(lat == 2, "R2 buffer hit latency", lat, 2);
                check(st == 1, "R8 stall length", st, 1);
            end else begin
                check(lat > 2, "R4 full miss (R10 cold)", lat, 3);
                check(st == lat - 1, "R8 stall length", st, lat - 1);
            end
            if (!VEC[k].wr)
                check(rd == model[VEC[k].addr[11:2]], "R3 R5 read data", rd,
                      model[VEC[k].addr[11:2]]);
        end
        check(wb_count == 0, "R7 no writeback yet", wb_count, 0);

        // fill the buffer: invalid slots first (R6)
        miss_read(12'h810, "R4 conflict C");
        miss_read(12'hC10, "R4 conflict D");
        miss_read(12'h020, "R4 fill E");
        miss_read(12'h420, "R4 fill F");
        check(wb_count == 0, "R6 invalid entries used first", wb_count, 0);
        miss_read(12'h820, "R4 fill G");
        check(wb_count == 0, "R6 clean LRU entry dropped", wb_count, 0);
        miss_read(12'hC20, "R4 fill H");
        check(wb_count == 1, "R6 R7 dirty LRU written back", wb_count, 1);
        check(last_wb_addr == 8'h01, "R7 writeback address", last_wb_addr, 8'h01);
        check(last_wr_ev < last_rd_ev, "R7 writeback before refill", last_wr_ev, last_rd_ev);
        check(backing[12'h014 >> 2] == WV, "R5 dirty data written back",
              backing[12'h014 >> 2], WV);
        miss_read(12'h014, "R5 written word from memory");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule